// File: doc/BRIEF.md
# Pixel Clock Divider Pair Search Engine

This engine picks the setting of a two-stage clock divider (a fractional stage followed by an integer stage) that brings a derived pixel clock as close as possible to a requested rate. Software or a sequencer gives it the parent clock rate and the wanted rate, both in kHz, and pulses start. The engine then scores every legal pair of stage values in turn. When the sweep ends it reports the winning pair, the signed residual error, and whether any candidate was acceptable at all.

All arithmetic uses four fractional bits. The fractional stage contributes a rounded fixed-point factor equal to 18 divided by the fractional value. Each candidate rate is the parent rate times that factor, divided by the integer value with round-to-nearest. The division for each candidate runs on a small iterative restoring divider that retires several quotient bits per cycle. The block stops at the chosen numbers. Programming them into clock control registers belongs to other logic.

Top module: `clkdiv_search`

## Requirements
- R1: A search scores exactly 4590 candidates. The fractional value is the outer loop and runs upward from 18 to 35. The integer value is the inner loop and runs upward from 1 to 255.
- R2: For fractional value f, the factor is ((18 / f) << 4) + ((((18 mod f) << 4) + f/2) / f), using integer division. For example, f=18 gives 16 and f=19 gives 15.
- R3: The candidate rate for integer value d is (parent * factor + d/2) / d, using integer division, so the result is rounded to nearest.
- R4: The error of a candidate is (target << 4) minus the candidate rate, as a signed number. The value reported on err_o is the error of the chosen pair.
- R5: A candidate replaces the held best only when the magnitude of its error is strictly smaller. If several candidates have the same magnitude, the one scored first wins.
- R6: The held best error starts each search at 0xFFFFFF. If no candidate improves on it, the search fails: fail_o=1, frac_o=0, div_o=0 and err_o=0xFFFFFF. Otherwise fail_o=0.
- R7: busy_o is high from the cycle after an accepted start until the sweep ends. done_o is high for exactly one cycle, and the results are valid in that same cycle.
- R8: A start pulse that arrives while busy_o is high is ignored. The running search finishes with the inputs captured at its own start.
- R9: After done_o, the results stay unchanged until the next accepted start, even if parent_khz_i and target_khz_i change.
- R10: After reset, busy_o, done_o and fail_o are 0, and frac_o, div_o and err_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; sampled only when idle |
| parent_khz_i | input | PAR_W | Parent clock rate in kHz |
| target_khz_i | input | TGT_W | Requested pixel clock in kHz |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse when the results become valid |
| fail_o | output | 1 | No candidate beat the initial error bound |
| frac_o | output | 6 | Chosen fractional value (0 when the search fails) |
| div_o | output | 8 | Chosen integer value (0 when the search fails) |
| err_o | output | DW+2 | Signed error of the chosen pair, with 4 fractional bits |

## Verification
The assertions check the following on every cycle:
- both loop counters stay inside their legal ranges while the engine is busy;
- the held error magnitude never grows during a sweep;
- done_o lasts a single cycle, and a failed search reports zero settings;
- the results stay frozen while the engine is idle;
- the divider only accepts new work when it is free.

The values of the chosen pair can only be shown by the bench scenarios, which compare them against an independent model of the rounded fixed-point sweep. These scenarios include a typical display rate, an exact-tie case in which the earliest zero-error pair must win, a case that fails, and a start pulse sent in the middle of a run.

// File: rtl/cds_pkg.sv
package cds_pkg;
    // Search space of the two divider stages
    localparam int FRAC_W    = 6;
    localparam int IDIV_W    = 8;
    localparam int FRAC_LO   = 18;
    localparam int FRAC_HI   = 35;
    localparam int IDIV_LO   = 1;
    localparam int IDIV_HI   = 255;
    // Fixed-point format of the stage factor
    localparam int FXP_BITS  = 4;
    localparam int RATIO_NUM = 18;
    localparam int RATIO_W   = 6;
    // Best-error seed; a search that never beats it fails
    localparam int SEED_ERR  = 24'hFFFFFF;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_WAIT   = 2'd2,
        ST_FINISH = 2'd3
    } cds_state_e;
endpackage

// File: rtl/cds_ratio.sv
// Rounded fixed-point factor RATIO_NUM / frac with FXP_BITS fraction bits.
module cds_ratio
    import cds_pkg::*;
(
    input  logic [FRAC_W-1:0]  frac_i,
    output logic [RATIO_W-1:0] ratio_o
);
    localparam int TW = 12;

    logic [TW-1:0] num_w;
    logic [TW-1:0] den_w;
    logic [TW-1:0] whole_w;
    logic [TW-1:0] rem_w;
    logic [TW-1:0] fine_w;
    logic [TW-1:0] sum_w;

    always_comb begin
        num_w   = TW'(RATIO_NUM);
        den_w   = TW'(frac_i);
        whole_w = '0;
        rem_w   = '0;
        fine_w  = '0;
        if (den_w != '0) begin
            whole_w = num_w / den_w;
            rem_w   = num_w % den_w;
            fine_w  = ((rem_w << FXP_BITS) + (den_w >> 1)) / den_w;
        end
        sum_w   = (whole_w << FXP_BITS) + fine_w;
        ratio_o = sum_w[RATIO_W-1:0];
    end

    // R2: inside the swept range the factor always lies between 8 and 16
    always_comb begin
        if (frac_i >= FRAC_W'(FRAC_LO) && frac_i <= FRAC_W'(FRAC_HI)) begin
            ratio_range_chk: assert (ratio_o >= RATIO_W'(8) && ratio_o <= RATIO_W'(16))
                else $error("factor out of range");
        end
    end
endmodule

// File: rtl/cds_div.sv
// Iterative restoring divider that retires SB quotient bits per cycle.
module cds_div #(
    parameter int DW = 40,
    parameter int VW = 8,
    parameter int SB = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [DW-1:0] num_i,
    input  logic [VW-1:0] den_i,
    output logic          busy_o,
    output logic          valid_o,
    output logic [DW-1:0] quo_o
);
    localparam int STEPS = DW / SB;
    localparam int CW    = $clog2(STEPS) + 1;

    typedef struct packed {
        logic          busy;
        logic          valid;
        logic [CW-1:0] cnt;
        logic [DW-1:0] acc;
        logic [VW:0]   rem;
        logic [VW-1:0] den;
    } dv_t;

    dv_t           dv_d, dv_q;
    logic [VW:0]   r_w;
    logic [DW-1:0] s_w;

    always_comb begin
        dv_d       = dv_q;
        dv_d.valid = 1'b0;
        r_w        = dv_q.rem;
        s_w        = dv_q.acc;
        if (!dv_q.busy) begin
            if (start_i) begin
                dv_d.busy = 1'b1;
                dv_d.cnt  = '0;
                dv_d.acc  = num_i;
                dv_d.rem  = '0;
                dv_d.den  = den_i;
            end
        end else begin
            for (int k = 0; k < SB; k++) begin
                r_w = {r_w[VW-1:0], s_w[DW-1]};
                s_w = {s_w[DW-2:0], 1'b0};
                if (r_w >= {1'b0, dv_q.den}) begin
                    r_w    = r_w - {1'b0, dv_q.den};
                    s_w[0] = 1'b1;
                end
            end
            dv_d.acc = s_w;
            dv_d.rem = r_w;
            dv_d.cnt = dv_q.cnt + CW'(1);
            if (dv_q.cnt == CW'(STEPS - 1)) begin
                dv_d.busy  = 1'b0;
                dv_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dv_q <= '0;
        else        dv_q <= dv_d;
    end

    assign busy_o  = dv_q.busy;
    assign valid_o = dv_q.valid;
    assign quo_o   = dv_q.acc;

    // R3
    div_start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !dv_q.busy)
        else $error("divider started while busy");

    // R3
    div_valid_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dv_q.valid |-> (!dv_q.busy && $past(dv_q.busy)))
        else $error("quotient valid without a run");
endmodule

// File: rtl/cds_track.sv
// Holds the best candidate seen so far under a strict-improvement rule.
module cds_track
    import cds_pkg::*;
#(
    parameter int EW = 42
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear_i,
    input  logic                 cand_valid_i,
    input  logic signed [EW-1:0] cand_err_i,
    input  logic [FRAC_W-1:0]    cand_frac_i,
    input  logic [IDIV_W-1:0]    cand_div_i,
    output logic signed [EW-1:0] best_err_o,
    output logic [FRAC_W-1:0]    best_frac_o,
    output logic [IDIV_W-1:0]    best_div_o,
    output logic                 found_o
);
    typedef struct packed {
        logic signed [EW-1:0] err;
        logic [FRAC_W-1:0]    frac;
        logic [IDIV_W-1:0]    idiv;
        logic                 found;
    } bt_t;

    bt_t bt_d, bt_q;

    function automatic logic [EW-1:0] mag(input logic signed [EW-1:0] v);
        return (v < 0) ? EW'(-v) : EW'(v);
    endfunction

    always_comb begin
        bt_d = bt_q;
        if (clear_i) begin
            bt_d.err   = EW'(SEED_ERR);
            bt_d.frac  = '0;
            bt_d.idiv  = '0;
            bt_d.found = 1'b0;
        end else if (cand_valid_i && (mag(cand_err_i) < mag(bt_q.err))) begin
            bt_d.err   = cand_err_i;
            bt_d.frac  = cand_frac_i;
            bt_d.idiv  = cand_div_i;
            bt_d.found = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bt_q       <= '0;
            bt_q.err   <= EW'(SEED_ERR);
        end else begin
            bt_q       <= bt_d;
        end
    end

    assign best_err_o  = bt_q.err;
    assign best_frac_o = bt_q.frac;
    assign best_div_o  = bt_q.idiv;
    assign found_o     = bt_q.found;

    // R5
    best_mag_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> (mag(bt_q.err) <= $past(mag(bt_q.err))))
        else $error("best error magnitude grew");

    // R6
    found_has_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bt_q.found |-> (bt_q.frac >= FRAC_W'(FRAC_LO) && bt_q.idiv != '0))
        else $error("found without a legal pair");
endmodule

// File: rtl/clkdiv_search.sv
// Exhaustive search over fractional x integer divider pairs.
module clkdiv_search
    import cds_pkg::*;
#(
    parameter int PAR_W = 24,
    parameter int TGT_W = 24,
    parameter int DW    = 40,
    parameter int SB    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [PAR_W-1:0]     parent_khz_i,
    input  logic [TGT_W-1:0]     target_khz_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 fail_o,
    output logic [FRAC_W-1:0]    frac_o,
    output logic [IDIV_W-1:0]    div_o,
    output logic signed [DW+1:0] err_o
);
    localparam int EW = DW + 2;

    typedef struct packed {
        cds_state_e           st;
        logic [FRAC_W-1:0]    frac;
        logic [IDIV_W-1:0]    idiv;
        logic [PAR_W-1:0]     parent;
        logic [TGT_W-1:0]     target;
        logic                 done;
        logic                 fail;
        logic [FRAC_W-1:0]    out_frac;
        logic [IDIV_W-1:0]    out_div;
        logic signed [EW-1:0] out_err;
    } eng_t;

    eng_t eng_d, eng_q;

    logic [RATIO_W-1:0]   ratio_w;
    logic [DW-1:0]        dividend_w;
    logic                 dv_start_w;
    logic                 dv_busy_w;
    logic                 dv_valid_w;
    logic [DW-1:0]        dv_quo_w;
    logic [EW-1:0]        tgt_ext_w;
    logic signed [EW-1:0] cand_err_w;
    logic                 trk_clear_w;
    logic                 cand_valid_w;
    logic signed [EW-1:0] best_err_w;
    logic [FRAC_W-1:0]    best_frac_w;
    logic [IDIV_W-1:0]    best_div_w;
    logic                 found_w;

    cds_ratio u_ratio (
        .frac_i  (eng_q.frac),
        .ratio_o (ratio_w)
    );

    assign dividend_w = (DW'(eng_q.parent) * DW'(ratio_w)) + DW'(eng_q.idiv >> 1);

    cds_div #(.DW(DW), .VW(IDIV_W), .SB(SB)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (dv_start_w),
        .num_i   (dividend_w),
        .den_i   (eng_q.idiv),
        .busy_o  (dv_busy_w),
        .valid_o (dv_valid_w),
        .quo_o   (dv_quo_w)
    );

    assign tgt_ext_w  = EW'({eng_q.target, {FXP_BITS{1'b0}}});
    assign cand_err_w = $signed(tgt_ext_w) - $signed({2'b00, dv_quo_w});

    cds_track #(.EW(EW)) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (trk_clear_w),
        .cand_valid_i (cand_valid_w),
        .cand_err_i   (cand_err_w),
        .cand_frac_i  (eng_q.frac),
        .cand_div_i   (eng_q.idiv),
        .best_err_o   (best_err_w),
        .best_frac_o  (best_frac_w),
        .best_div_o   (best_div_w),
        .found_o      (found_w)
    );

    always_comb begin
        eng_d        = eng_q;
        eng_d.done   = 1'b0;
        trk_clear_w  = 1'b0;
        dv_start_w   = 1'b0;
        cand_valid_w = 1'b0;
        unique case (eng_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    eng_d.parent = parent_khz_i;
                    eng_d.target = target_khz_i;
                    eng_d.frac   = FRAC_W'(FRAC_LO);
                    eng_d.idiv   = IDIV_W'(IDIV_LO);
                    trk_clear_w  = 1'b1;
                    eng_d.st     = ST_LAUNCH;
                end
            end
            ST_LAUNCH: begin
                dv_start_w = 1'b1;
                eng_d.st   = ST_WAIT;
            end
            ST_WAIT: begin
                if (dv_valid_w) begin
                    cand_valid_w = 1'b1;
                    if (eng_q.idiv == IDIV_W'(IDIV_HI)) begin
                        if (eng_q.frac == FRAC_W'(FRAC_HI)) begin
                            eng_d.st = ST_FINISH;
                        end else begin
                            eng_d.frac = eng_q.frac + FRAC_W'(1);
                            eng_d.idiv = IDIV_W'(IDIV_LO);
                            eng_d.st   = ST_LAUNCH;
                        end
                    end else begin
                        eng_d.idiv = eng_q.idiv + IDIV_W'(1);
                        eng_d.st   = ST_LAUNCH;
                    end
                end
            end
            ST_FINISH: begin
                eng_d.done     = 1'b1;
                eng_d.fail     = !found_w;
                eng_d.out_frac = found_w ? best_frac_w : '0;
                eng_d.out_div  = found_w ? best_div_w : '0;
                eng_d.out_err  = best_err_w;
                eng_d.st       = ST_IDLE;
            end
            default: eng_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '{st: ST_IDLE, default: '0};
        else        eng_q <= eng_d;
    end

    assign busy_o = (eng_q.st != ST_IDLE);
    assign done_o = eng_q.done;
    assign fail_o = eng_q.fail;
    assign frac_o = eng_q.out_frac;
    assign div_o  = eng_q.out_div;
    assign err_o  = eng_q.out_err;

    // R1
    loop_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (eng_q.frac >= FRAC_W'(FRAC_LO) && eng_q.frac <= FRAC_W'(FRAC_HI)
                    && eng_q.idiv >= IDIV_W'(IDIV_LO)))
        else $error("loop counters out of range");

    // R3
    launch_free_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == ST_LAUNCH) |-> !dv_busy_w)
        else $error("launch while divider busy");

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o)
        else $error("done longer than one cycle");

    // R6
    fail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fail_o) |-> (frac_o == '0 && div_o == '0))
        else $error("failed search reported settings");

    // R8
    start_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(eng_q.parent) && $stable(eng_q.target)))
        else $error("start accepted while busy");

    // R9
    results_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(frac_o) && $stable(div_o)
                                   && $stable(err_o) && $stable(fail_o)))
        else $error("results changed while idle");
endmodule

// File: tb/sim_clkdiv_search.sv
`timescale 1ns/1ps
module sim_clkdiv_search;
    localparam int PAR_W = 24;
    localparam int TGT_W = 24;
    localparam int DW    = 40;
    localparam int EW    = DW + 2;

    typedef struct {
        bit     fail;
        int     frac;
        int     idiv;
        longint err;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [PAR_W-1:0] parent = '0;
    logic [TGT_W-1:0] target = '0;
    logic             busy, done, fail;
    logic [5:0]       frac;
    logic [7:0]       idiv;
    logic signed [EW-1:0] err;

    int   checks = 0;
    int   errors = 0;
    int   jobs_seen = 0;
    bit   prev_done = 1'b0;
    exp_t sb_q[$];
    exp_t last_exp;

    always #4 clk = ~clk;

    clkdiv_search #(.PAR_W(PAR_W), .TGT_W(TGT_W), .DW(DW), .SB(8)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .parent_khz_i (parent),
        .target_khz_i (target),
        .busy_o       (busy),
        .done_o       (done),
        .fail_o       (fail),
        .frac_o       (frac),
        .div_o        (idiv),
        .err_o        (err)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Independent model of the sweep (R1..R6)
    function automatic exp_t model(input longint p, input longint t);
        exp_t e;
        longint best = 64'hFFFFFF;
        e.fail = 1'b1; e.frac = 0; e.idiv = 0;
        for (int f = 18; f <= 35; f++) begin
            longint r = ((18 / f) << 4) + ((((18 % f) << 4) + f / 2) / f);
            for (int d = 1; d <= 255; d++) begin
                longint c  = (p * r + d / 2) / d;
                longint ev = (t << 4) - c;
                longint ae = (ev < 0) ? -ev : ev;
                longint ab = (best < 0) ? -best : best;
                if (ae < ab) begin
                    best = ev; e.frac = f; e.idiv = d; e.fail = 1'b0;
                end
            end
        end
        e.err = best;
        return e;
    endfunction

    // Driver: pushes the expected item and launches the job
    task automatic run_job(input longint p, input longint t, input bit poke);
        exp_t e = model(p, t);
        int   want = jobs_seen + 1;
        sb_q.push_back(e);
        last_exp = e;
        @(negedge clk);
        parent = PAR_W'(p); target = TGT_W'(t); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R7: busy rises the cycle after start
        check(busy === 1'b1, "R7 busy", busy, 1);
        if (poke) begin
            repeat (3000) @(negedge clk);
            // R8: start with other inputs in mid-run is ignored
            parent = 24'd123456; target = 24'd777; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait (jobs_seen == want);
    endtask

    // Monitor: pops and compares on done
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done) check(done === 1'b0, "R7 done width", done, 0);
            if (done) begin
                exp_t e;
                if (sb_q.size() == 0) begin
                    check(1'b0, "R7 unexpected done", 1, 0);
                end else begin
                    e = sb_q.pop_front();
                    check(fail === e.fail, "R6 fail", fail, e.fail);
                    check(int'(frac) == e.frac, "R1 R2 frac", frac, e.frac);
                    check(int'(idiv) == e.idiv, "R3 R5 div", idiv, e.idiv);
                    check(longint'(err) == e.err, "R4 err", longint'(err), e.err);
                end
                jobs_seen++;
            end
            prev_done = done;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog expired actual=%0d expected=%0d", jobs_seen, 4);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(busy === 1'b0, "R10 busy", busy, 0);
        check(done === 1'b0, "R10 done", done, 0);
        check(fail === 1'b0, "R10 fail", fail, 0);
        check(frac == 0 && idiv == 0, "R10 settings", {frac, idiv}, 0);
        check(err == 0, "R10 err", longint'(err), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Typical display rate, with an ignored mid-run start (R8)
        run_job(480000, 33000, 1'b1);

        // R9: results hold through idle cycles with changed inputs
        parent = 24'd1; target = 24'd5;
        repeat (20) @(negedge clk);
        check(int'(frac) == last_exp.frac, "R9 frac hold", frac, last_exp.frac);
        check(int'(idiv) == last_exp.idiv, "R9 div hold", idiv, last_exp.idiv);
        check(longint'(err) == last_exp.err, "R9 err hold", longint'(err), last_exp.err);

        // Second rate pattern
        run_job(480000, 6500, 1'b0);

        // R5: ties resolved toward the earliest pair (frac 18, div 33, err 0)
        run_job(1, 0, 1'b0);
        check(frac == 6'd18, "R5 tie frac", frac, 18);
        check(idiv == 8'd33, "R5 tie div", idiv, 33);
        check(err == 0, "R5 tie err", longint'(err), 0);

        // R6: nothing beats the seed
        run_job(1, 2000000, 1'b0);
        check(fail === 1'b1, "R6 fail flag", fail, 1);
        check(longint'(err) == 64'hFFFFFF, "R6 seed err", longint'(err), 64'hFFFFFF);

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule